// File: doc/BRIEF.md
# Configurable Output Cell Array

This block is the output stage of a small sum-of-products logic plane. It holds eight output cells. Each cell receives eight product terms from an AND-array outside the block, ORs them into a sum, and sets the polarity of that sum with an XOR. For each cell the block produces a pin drive value, an output enable and a feedback bit that goes back into the array. A single global mode selects how the cells work. The registered mode provides clocked state machines with a shared output enable. The complex mode gives combinational outputs whose enable comes from a product term. The simple mode gives combinational outputs whose enables are fixed.

The global mode is sampled only while reset is held, so software or configuration logic can change it only through a reset. The per-cell configuration bits are register select, output/input use and polarity. They are expected to stay constant while the block runs. The product terms, the pin levels and the two shared-pin levels are ordinary inputs. They can change in any cycle.

Top module: `macrocell_bank`

## Requirements
- R1: While `rst_n` is low, every cell register is cleared to 0. A cell that is registered in registered mode therefore drives 1 on `pin_drv` and returns 1 on `fb` until its first capture.
- R2: `mode_sel` is sampled on each rising clock edge while `rst_n` is low and is ignored while `rst_n` is high. The encoding is 2'b00 simple, 2'b01 complex, and 2'b10 or 2'b11 registered.
- R3: In registered mode, a cell with `cell_reg` = 1 and `cell_out` = 1 captures the OR of all eight of its terms, XOR its `cell_inv` bit, on each rising edge. It drives the inverse of its register on `pin_drv`, returns the same inverse on `fb`, and sets its enable to the inverse of `oe_n`.
- R4: In registered mode, a cell with `cell_reg` = 0 and `cell_out` = 1 is combinational. Its enable is term 0, its drive is the OR of terms 1 to 7 XOR `cell_inv`, and its feedback is its own `pin_in` bit.
- R5: In registered mode, a cell with `cell_out` = 0 is an input whatever its `cell_reg` bit. Its enable is 0 and its feedback is its own `pin_in` bit.
- R6: In complex mode, every cell drives the OR of terms 1 to 7 XOR `cell_inv` and is enabled by term 0, and `cell_reg` and `cell_out` have no effect. Cells 1 to 6 feed back their own `pin_in` bit. Cell 0 carries the `oe_n` level instead, and cell 7 carries `gck_lvl`.
- R7: In simple mode, every cell drives the OR of all eight terms XOR `cell_inv`. Cells 3 and 4 are always enabled. Every other cell is enabled by its `cell_out` bit.
- R8: In simple mode, the feedback comes from the neighbouring pin toward the edge. Cell 0 carries `oe_n`, and cells 1, 2 and 3 carry pins 0, 1 and 2. Cell 7 carries `gck_lvl`, and cells 6, 5 and 4 carry pins 7, 6 and 5. The pins of cells 3 and 4 reach no feedback.
- R9: Term j of cell i is `pterm[8*i+j]`. A `cell_inv` bit of 1 inverts that cell's sum before it is driven or registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the cell registers |
| rst_n | input | 1 | Active-low reset; clears registers and admits `mode_sel` |
| mode_sel | input | 2 | Global mode, sampled only during reset |
| pterm | input | 64 | Product terms, eight per cell |
| cell_reg | input | 8 | Per-cell register select (registered mode) |
| cell_out | input | 8 | Per-cell output use (1) or input use (0) |
| cell_inv | input | 8 | Per-cell polarity XOR |
| pin_in | input | 8 | Present levels of the eight cell pins |
| oe_n | input | 1 | Shared active-low enable for registered cells |
| gck_lvl | input | 1 | Level of the shared clock pin when used as data |
| pin_drv | output | 8 | Drive value for each cell pin |
| pin_en | output | 8 | Output enable for each cell pin |
| fb | output | 8 | Feedback bit returned to the array per cell |

## Verification
The bench targets the feedback lines at the edge and in the centre. If the simple-mode map is wrong, a pin appears on the wrong array line, or a centre pin leaks back into the array. If the complex-mode handling is wrong, the shared pins fail to reach cells 0 and 7. Another target is splitting term 0 off as an enable. A design that still ORs it into the sum gives the wrong drive whenever only term 0 is set. The bench also changes the mode while the block runs; a design that does not hold the mode would switch the enables at once. Finally it checks that registered outputs read high out of reset. A register that is not inverted would read low.

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
  parameter int CELLS = 8,
  parameter int TERMS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_sel,
  input  logic [CELLS*TERMS-1:0] pterm,
  input  logic [CELLS-1:0]       cell_reg,
  input  logic [CELLS-1:0]       cell_out,
  input  logic [CELLS-1:0]       cell_inv,
  input  logic [CELLS-1:0]       pin_in,
  input  logic                   oe_n,
  input  logic                   gck_lvl,
  output logic [CELLS-1:0]       pin_drv,
  output logic [CELLS-1:0]       pin_en,
  output logic [CELLS-1:0]       fb
);
  localparam int HALF = CELLS / 2;

  logic [1:0]       mode_q;
  logic [CELLS-1:0] q;
  logic [CELLS-1:0] d_vec;
  logic             is_reg, is_cplx, is_simp;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_sel;

  assign is_reg  = mode_q[1];
  assign is_cplx = (mode_q == 2'b01);
  assign is_simp = (mode_q == 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      q <= '0;
    else if (is_reg) q <= d_vec;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam bit CENTRE = (i == HALF - 1) || (i == HALF);
    logic [TERMS-1:0] t;
    logic s_all, s_rest, rcell, use_rest, comb_v;
    logic fb_simple, fb_cplx;

    assign t        = pterm[i*TERMS +: TERMS];
    assign s_all    = |t;
    assign s_rest   = |t[TERMS-1:1];
    assign rcell    = is_reg & cell_reg[i] & cell_out[i];
    assign use_rest = is_cplx | (is_reg & ~rcell);
    assign comb_v   = (use_rest ? s_rest : s_all) ^ cell_inv[i];
    assign d_vec[i] = s_all ^ cell_inv[i];

    if (i == 0) begin : g_lo
      assign fb_simple = oe_n;
      assign fb_cplx   = oe_n;
    end else if (i == CELLS - 1) begin : g_hi
      assign fb_simple = gck_lvl;
      assign fb_cplx   = gck_lvl;
    end else if (i < HALF) begin : g_lower
      assign fb_simple = pin_in[i-1];
      assign fb_cplx   = pin_in[i];
    end else begin : g_upper
      assign fb_simple = pin_in[i+1];
      assign fb_cplx   = pin_in[i];
    end

    assign pin_drv[i] = rcell ? ~q[i] : comb_v;

    always_comb begin
      if (is_reg) begin
        if (rcell)            pin_en[i] = ~oe_n;
        else if (cell_out[i]) pin_en[i] = t[0];
        else                  pin_en[i] = 1'b0;
      end else if (is_cplx) begin
        pin_en[i] = t[0];
      end else begin
        pin_en[i] = CENTRE ? 1'b1 : cell_out[i];
      end
    end

    always_comb begin
      if (is_reg)       fb[i] = rcell ? ~q[i] : pin_in[i];
      else if (is_cplx) fb[i] = fb_cplx;
      else              fb[i] = fb_simple;
    end
  end
endmodule

// File: rtl/macrocell_bank_chk.sv
module macrocell_bank_chk #(
  parameter int CELLS = 8,
  parameter int TERMS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   is_reg,
  input logic                   is_cplx,
  input logic                   is_simp,
  input logic [CELLS-1:0]       q,
  input logic [CELLS*TERMS-1:0] pterm,
  input logic [CELLS-1:0]       cell_reg,
  input logic [CELLS-1:0]       cell_out,
  input logic [CELLS-1:0]       cell_inv,
  input logic [CELLS-1:0]       pin_in,
  input logic                   oe_n,
  input logic                   gck_lvl,
  input logic [CELLS-1:0]       pin_drv,
  input logic [CELLS-1:0]       pin_en,
  input logic [CELLS-1:0]       fb
);
  localparam int HALF = CELLS / 2;

  always @(posedge clk)
    if (!rst_n) p_reset_clear_r1: assert (q == '0) else $error("register not cleared in reset");

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable({is_reg, is_cplx, is_simp}));

  p_centre_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_simp |-> (pin_en[HALF-1] && pin_en[HALF]));

  p_cplx_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_cplx |-> (fb[0] == oe_n && fb[CELLS-1] == gck_lvl));

  for (genvar i = 0; i < CELLS; i++) begin : g_c
    p_reg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_reg && cell_reg[i] && cell_out[i]) |=>
        (pin_drv[i] == $past(!((|pterm[i*TERMS +: TERMS]) ^ cell_inv[i]))));
    p_reg_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_reg && cell_reg[i] && cell_out[i]) |-> (pin_en[i] == !oe_n));
    p_input_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_reg && !cell_out[i]) |-> (!pin_en[i] && fb[i] == pin_in[i]));
  end
endmodule

bind macrocell_bank macrocell_bank_chk #(.CELLS(CELLS), .TERMS(TERMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_reg(is_reg), .is_cplx(is_cplx), .is_simp(is_simp),
  .q(q), .pterm(pterm), .cell_reg(cell_reg), .cell_out(cell_out), .cell_inv(cell_inv),
  .pin_in(pin_in), .oe_n(oe_n), .gck_lvl(gck_lvl), .pin_drv(pin_drv), .pin_en(pin_en),
  .fb(fb)
);

// File: tb/macrocell_bank_bench.sv
module macrocell_bank_bench;
  typedef struct packed {
    logic [1:0]  m;
    logic [7:0]  creg, cout, inv, pin;
    logic        oe_n, gck;
    logic [63:0] pt;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'd0, 8'h00, 8'hF0, 8'h00, 8'hA6, 1'b1, 1'b0, 64'h0001_0200_8000_0004},
    '{2'd0, 8'hFF, 8'h0F, 8'h55, 8'h3C, 1'b0, 1'b1, 64'h8000_0000_0000_0100},
    '{2'd1, 8'h00, 8'hFF, 8'h00, 8'h5A, 1'b1, 1'b1, 64'h0103_0201_0080_01FE},
    '{2'd1, 8'hFF, 8'h00, 8'hC3, 8'hF0, 1'b0, 1'b0, 64'h0100_0001_0200_0103},
    '{2'd2, 8'hFF, 8'hFF, 8'h00, 8'h0F, 1'b0, 1'b0, 64'h0100_0400_0000_20FF},
    '{2'd2, 8'h0F, 8'hFF, 8'h0F, 8'hAA, 1'b0, 1'b1, 64'h0001_0300_0102_0001},
    '{2'd3, 8'hF0, 8'h3C, 8'hA5, 8'h96, 1'b1, 1'b0, 64'hFF00_0101_0200_0103},
    '{2'd2, 8'h33, 8'hCC, 8'hFF, 8'h81, 1'b0, 1'b1, 64'h0000_0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd2;
  logic [63:0] pterm = '0;
  logic [7:0]  cell_reg = '0, cell_out = '0, cell_inv = '0, pin_in = '0;
  logic        oe_n = 1'b0, gck_lvl = 1'b0;
  logic [7:0]  pin_drv, pin_en, fb;
  logic [7:0]  qm;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  macrocell_bank u_macrocell_bank (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pterm(pterm),
    .cell_reg(cell_reg), .cell_out(cell_out), .cell_inv(cell_inv),
    .pin_in(pin_in), .oe_n(oe_n), .gck_lvl(gck_lvl),
    .pin_drv(pin_drv), .pin_en(pin_en), .fb(fb)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic reset_into(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    qm = '0;
  endtask

  task automatic apply(input vec_t v);
    cell_reg = v.creg; cell_out = v.cout; cell_inv = v.inv;
    pin_in = v.pin; oe_n = v.oe_n; gck_lvl = v.gck; pterm = v.pt;
  endtask

  function automatic logic [23:0] model(input vec_t v, input logic [7:0] qv);
    logic [7:0] d, e, f, t;
    logic all_s, rest_s;
    for (int i = 0; i < 8; i++) begin
      t = v.pt[i*8 +: 8];
      all_s = |t;
      rest_s = |t[7:1];
      if (v.m == 2'd0) begin
        d[i] = all_s ^ v.inv[i];
        e[i] = (i == 3 || i == 4) ? 1'b1 : v.cout[i];
        if (i == 0) f[i] = v.oe_n;
        else if (i == 7) f[i] = v.gck;
        else if (i < 4) f[i] = v.pin[i-1];
        else f[i] = v.pin[i+1];
      end else if (v.m == 2'd1) begin
        d[i] = rest_s ^ v.inv[i];
        e[i] = t[0];
        f[i] = (i == 0) ? v.oe_n : (i == 7) ? v.gck : v.pin[i];
      end else if (v.creg[i] && v.cout[i]) begin
        d[i] = ~qv[i]; e[i] = ~v.oe_n; f[i] = ~qv[i];
      end else begin
        d[i] = rest_s ^ v.inv[i];
        e[i] = v.cout[i] ? t[0] : 1'b0;
        f[i] = v.pin[i];
      end
    end
    return {d, e, f};
  endfunction

  task automatic compare(input vec_t v, input string req);
    logic [23:0] x;
    x = model(v, qm);
    chk(req, "drive", pin_drv & x[15:8], x[23:16] & x[15:8]);
    chk(req, "enable", pin_en, x[15:8]);
    chk(req, "feedback", fb, x[7:0]);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tag;
    // table walk
    for (int k = 0; k < 8; k++) begin
      reset_into(VEC[k].m);
      apply(VEC[k]);
      tag = VEC[k].m[1] ? "R3" : (VEC[k].m == 2'd1) ? "R6" : "R7";
      #1 compare(VEC[k], tag);
      @(posedge clk);
      if (VEC[k].m[1])
        for (int i = 0; i < 8; i++) qm[i] = (|VEC[k].pt[i*8 +: 8]) ^ VEC[k].inv[i];
      @(negedge clk);
      #1 compare(VEC[k], tag);
    end

    // R1: reset values of registered cells
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 2'd2;
    cell_reg = 8'hFF; cell_out = 8'hFF; cell_inv = 8'h00; oe_n = 1'b0;
    pterm = {64{1'b1}}; pin_in = 8'h00;
    @(negedge clk); #1;
    chk("R1", "drive in reset", pin_drv, 8'hFF);
    chk("R1", "feedback in reset", fb, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R3", "drive after capture", pin_drv, 8'h00);
    chk("R3", "enable from oe_n low", pin_en, 8'hFF);

    // R2: mode change while running is ignored
    mode_sel = 2'd0; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R2", "enable after running mode change", pin_en, 8'h00);
    reset_into(2'd0);
    #1 chk("R2", "enable after mode taken in reset", pin_en, 8'hFF);

    // R4: combinational cell in registered mode
    reset_into(2'd2);
    cell_reg = 8'h00; cell_out = 8'hFF; cell_inv = 8'h0F;
    pterm = {8{8'h02}};
    #1 chk("R4", "enable with term0 low", pin_en, 8'h00);
    pterm = {8{8'h01}};
    #1 chk("R4", "enable with term0 high", pin_en, 8'hFF);
    chk("R4", "drive excludes term0", pin_drv, 8'h0F);

    // R5: input cells
    cell_reg = 8'hFF; cell_out = 8'h00; pterm = {64{1'b1}}; pin_in = 8'h3C;
    #1 chk("R5", "input enable", pin_en, 8'h00);
    chk("R5", "input feedback", fb, 8'h3C);

    // R6: complex mode
    reset_into(2'd1);
    cell_reg = 8'hFF; cell_out = 8'h00; cell_inv = 8'h00;
    pterm = {8{8'h01}}; pin_in = 8'hFF; oe_n = 1'b0; gck_lvl = 1'b0;
    #1 chk("R6", "enable ignores cell bits", pin_en, 8'hFF);
    chk("R6", "drive excludes term0", pin_drv, 8'h00);
    chk("R6", "edge feedback", fb, 8'h7E);
    pterm = {8{8'h80}};
    #1 chk("R6", "enable off", pin_en, 8'h00);
    chk("R6", "drive from term7", pin_drv, 8'hFF);

    // R7, R9: simple mode enables and polarity
    reset_into(2'd0);
    cell_out = 8'h00; pterm = '0; cell_inv = 8'hFF;
    #1 chk("R7", "centre enables", pin_en, 8'h18);
    chk("R9", "inverted empty sum", pin_drv, 8'hFF);
    cell_inv = 8'h00; pterm = 64'h0000_0000_8000_0000;
    #1 chk("R9", "term 31 lands in cell 3", pin_drv, 8'h08);

    // R8: simple feedback map
    pin_in = 8'hA6; oe_n = 1'b1; gck_lvl = 1'b0;
    #1 chk("R8", "neighbour feedback", fb, 8'h5D);
    pin_in = 8'h18;
    #1 chk("R8", "centre pins unseen", fb, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule